// File: doc/BRIEF.md
# Flash Burst Write Sequencer

This block is a host-side controller that stores a run of consecutive words into a NOR flash array over its asynchronous command bus. A client gives a start address and a word count with a one-cycle `start` pulse. The client then supplies one data word per target location through a valid/ready handshake. The controller drives one-cycle write and read strobes. The flash part is outside the block.

Before the first word, the controller places the flash in its fast-program (unlock bypass) state. Each word then costs a two-write program command. After each command the controller polls status at the target address until the internal program finishes. It then reads the word back and compares it with the value requested. When the last word is done, or when any word fails, the controller leaves the fast-program state with a two-write exit command. It then pulses `done`. A failed run holds `error` high and reports the offending address on `err_addr` until the next run starts.

Top module: `flash_burst_writer`

## Requirements
- R1: A `start` with `word_count` equal to zero produces a `done` pulse with `error` low and no flash bus cycle at all.
- R2: A nonzero run begins with exactly three bus writes: 8'hAA to the first unlock address, 8'h55 to the second unlock address, then 8'h20 to the first unlock address.
- R3: Each word is fetched through one `wr_valid`/`wr_ready` handshake. It is then written as two bus writes: 8'hA0 (command byte in bits 7:0, upper bits zero), then the word itself at its target address. The cycle after a handshake always carries the 8'hA0 write.
- R4: After a word's program write, every read the controller issues targets that word's address. Polling ends when read bit 7 equals bit 7 of the written word.
- R5: If the read-back word differs from the requested word, the run ends with `error` high and `err_addr` equal to that word's address. No later word is requested or programmed. This includes an attempt to turn a 0 bit into a 1.
- R6: If a poll read shows bit 5 set while bit 7 still differs, the controller reads once more. If bit 7 still differs, the run fails as in R5.
- R7: If polling for one word lasts POLL_LIMIT read cycles without completion, the run fails as in R5.
- R8: Every nonzero run ends with two bus writes, 8'h90 then 8'h00, whether it succeeded or failed. A failure is followed at once by the 8'h90 write.
- R9: Words are programmed at `start_addr`, `start_addr`+1, … for `word_count` words, and a successful run leaves exactly those locations holding the supplied data.
- R10: `done` is a single-cycle pulse. `busy` is high from the cycle after `start` until the `done` cycle, and low after it. A `start` while busy is ignored.
- R11: The write strobe and the read strobe are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| start_addr | input | AW | First word address of the run |
| word_count | input | CW | Number of words to program |
| wr_valid | input | 1 | Client offers a data word |
| wr_data | input | DW | Data word offered |
| wr_ready | output | 1 | Controller accepts a word this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Last run failed |
| err_addr | output | AW | Address of the failing word |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | DW | Flash bus write data |
| fl_we | output | 1 | One-cycle write strobe |
| fl_rd | output | 1 | One-cycle read strobe, data sampled the same cycle |
| fl_rdata | input | DW | Flash bus read data |

## Verification
The assertions check the cycle-level rules on every cycle:
- the two strobes are never active together;
- `done` lasts one cycle;
- an accepted word is followed by the program command;
- every read targets the current word;
- a new failure is followed at once by the exit command;
- a zero count completes in the next cycle;
- the word address holds between steps;
- the poll counter stays inside its limit.

Only the bench's flash model can show the end-to-end effects. These are the exact command order, the final memory image over a sweep of start addresses, lengths and program latencies, and the stop-at-first-failure behaviour. The three failure causes (read-back mismatch, bit-5 failure and poll timeout) are also shown only by the model.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNL1,
        S_UNL2,
        S_BYP,
        S_FETCH,
        S_PCMD,
        S_PDATA,
        S_POLL,
        S_RECHK,
        S_VERIFY,
        S_EXIT1,
        S_EXIT2,
        S_FIN
    } fpw_state_e;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_BYPASS   = 8'h20;
    localparam logic [7:0] CMD_PROG     = 8'hA0;
    localparam logic [7:0] CMD_EXIT_A   = 8'h90;
    localparam logic [7:0] CMD_EXIT_B   = 8'h00;

    typedef struct packed {
        logic ready_bit;
        logic fail_bit;
    } poll_view_t;

    function automatic logic state_writes(fpw_state_e s);
        return (s == S_UNL1) || (s == S_UNL2) || (s == S_BYP) || (s == S_PCMD) ||
               (s == S_PDATA) || (s == S_EXIT1) || (s == S_EXIT2);
    endfunction

    function automatic logic state_reads(fpw_state_e s);
        return (s == S_POLL) || (s == S_RECHK) || (s == S_VERIFY);
    endfunction

    function automatic logic [7:0] cmd_for(fpw_state_e s);
        case (s)
            S_UNL1:  return CMD_UNLOCK_A;
            S_UNL2:  return CMD_UNLOCK_B;
            S_BYP:   return CMD_BYPASS;
            S_PCMD:  return CMD_PROG;
            S_EXIT1: return CMD_EXIT_A;
            default: return CMD_EXIT_B;
        endcase
    endfunction

    function automatic poll_view_t decode_poll(logic [7:0] low, logic want7);
        poll_view_t v;
        v.ready_bit = (low[7] == want7);
        v.fail_bit  = low[5];
        return v;
    endfunction

endpackage

// File: rtl/fpw_addr_ctr.sv
module fpw_addr_ctr #(
    parameter int unsigned AW = 22,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [CW-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr      <= '0;
            remaining <= '0;
        end else if (load) begin
            addr      <= base;
            remaining <= count;
        end else if (step) begin
            addr      <= addr + 1'b1;
            remaining <= remaining - 1'b1;
        end
    end

    assign last = (remaining == CW'(1));

    // R9: address only moves on a load or a step
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(addr));

endmodule

// File: rtl/fpw_poll_timer.sv
module fpw_poll_timer #(
    parameter int unsigned LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int unsigned TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    // R7: the wait counter never passes its bound
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt < TW'(LIMIT));

endmodule

// File: rtl/fpw_bus_mux.sv
module fpw_bus_mux
    import fpw_pkg::*;
#(
    parameter int unsigned AW            = 22,
    parameter int unsigned DW            = 16,
    parameter int unsigned UNLOCK_ADDR_A = 'h555,
    parameter int unsigned UNLOCK_ADDR_B = 'h2AA
) (
    input  fpw_state_e    state,
    input  logic [AW-1:0] word_addr,
    input  logic [DW-1:0] word_data,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    output logic          fl_we,
    output logic          fl_rd
);
    localparam logic [AW-1:0] UA = AW'(UNLOCK_ADDR_A);
    localparam logic [AW-1:0] UB = AW'(UNLOCK_ADDR_B);

    always_comb begin
        fl_we = state_writes(state);
        fl_rd = state_reads(state);
        if (state == S_PDATA || state_reads(state)) begin
            fl_addr = word_addr;
        end else if (state == S_UNL2) begin
            fl_addr = UB;
        end else begin
            fl_addr = UA;
        end
        if (state == S_PDATA) begin
            fl_wdata = word_data;
        end else begin
            fl_wdata = DW'(cmd_for(state));
        end
    end

endmodule

// File: rtl/flash_burst_writer.sv
module flash_burst_writer
    import fpw_pkg::*;
#(
    parameter int unsigned AW            = 22,
    parameter int unsigned DW            = 16,
    parameter int unsigned CW            = 16,
    parameter int unsigned POLL_LIMIT    = 4096,
    parameter int unsigned UNLOCK_ADDR_A = 'h555,
    parameter int unsigned UNLOCK_ADDR_B = 'h2AA
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] word_count,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          wr_ready,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] err_addr,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    output logic          fl_we,
    output logic          fl_rd,
    input  logic [DW-1:0] fl_rdata
);
    fpw_state_e    state, state_nx;
    logic [DW-1:0] data_q;
    logic          error_q;
    logic [AW-1:0] err_addr_q;
    logic [AW-1:0] cur_addr;
    logic          is_last;
    logic          ctr_load, ctr_step;
    logic          tmr_expired;
    logic          fail_now;
    poll_view_t    pv;

    assign pv = decode_poll(fl_rdata[7:0], data_q[7]);

    fpw_addr_ctr #(.AW(AW), .CW(CW)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .load  (ctr_load),
        .step  (ctr_step),
        .base  (start_addr),
        .count (word_count),
        .addr  (cur_addr),
        .last  (is_last)
    );

    fpw_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   (state == S_PDATA),
        .run     (state == S_POLL),
        .expired (tmr_expired)
    );

    fpw_bus_mux #(
        .AW(AW), .DW(DW),
        .UNLOCK_ADDR_A(UNLOCK_ADDR_A), .UNLOCK_ADDR_B(UNLOCK_ADDR_B)
    ) u_bus (
        .state     (state),
        .word_addr (cur_addr),
        .word_data (data_q),
        .fl_addr   (fl_addr),
        .fl_wdata  (fl_wdata),
        .fl_we     (fl_we),
        .fl_rd     (fl_rd)
    );

    always_comb begin
        state_nx = state;
        ctr_load = 1'b0;
        ctr_step = 1'b0;
        fail_now = 1'b0;
        case (state)
            S_IDLE: if (start) begin
                if (word_count == '0) begin
                    state_nx = S_FIN;
                end else begin
                    state_nx = S_UNL1;
                    ctr_load = 1'b1;
                end
            end
            S_UNL1:  state_nx = S_UNL2;
            S_UNL2:  state_nx = S_BYP;
            S_BYP:   state_nx = S_FETCH;
            S_FETCH: if (wr_valid) state_nx = S_PCMD;
            S_PCMD:  state_nx = S_PDATA;
            S_PDATA: state_nx = S_POLL;
            S_POLL: begin
                if (pv.ready_bit)      state_nx = S_VERIFY;
                else if (pv.fail_bit)  state_nx = S_RECHK;
                else if (tmr_expired)  fail_now = 1'b1;
            end
            S_RECHK: begin
                if (pv.ready_bit) state_nx = S_VERIFY;
                else              fail_now = 1'b1;
            end
            S_VERIFY: begin
                if (fl_rdata != data_q) begin
                    fail_now = 1'b1;
                end else if (is_last) begin
                    state_nx = S_EXIT1;
                end else begin
                    ctr_step = 1'b1;
                    state_nx = S_FETCH;
                end
            end
            S_EXIT1: state_nx = S_EXIT2;
            S_EXIT2: state_nx = S_FIN;
            S_FIN:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
        if (fail_now) state_nx = S_EXIT1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            data_q     <= '0;
            error_q    <= 1'b0;
            err_addr_q <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start) begin
                error_q    <= 1'b0;
                err_addr_q <= '0;
            end
            if (state == S_FETCH && wr_valid) data_q <= wr_data;
            if (fail_now) begin
                error_q    <= 1'b1;
                err_addr_q <= cur_addr;
            end
        end
    end

    assign wr_ready = (state == S_FETCH);
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_FIN);
    assign error    = error_q;
    assign err_addr = err_addr_q;

    // R11: write and read strobes are exclusive
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_rd));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: an accepted word is followed by the program command
    p_take_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (fl_we && fl_wdata[7:0] == CMD_PROG));

    // R4: every read targets the word in flight
    p_poll_addr_r4: assert property (@(posedge clk) disable iff (rst)
        fl_rd |-> (fl_addr == cur_addr));

    // R8: a fresh failure goes straight to the exit command
    p_err_exit_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> (fl_we && fl_wdata[7:0] == CMD_EXIT_A));

    // R1: empty request completes at once
    p_zero_done_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && word_count == '0) |=> (done && !fl_we && !fl_rd));

endmodule

// File: tb/flash_burst_writer_tb.sv
module flash_burst_writer_tb;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int LIM = 24;
    localparam int UA = 'h555;
    localparam int UB = 'h2AA;
    localparam int MS = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] word_count = '0;
    logic wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic wr_ready, busy, done, error, fl_we, fl_rd;
    logic [AW-1:0] err_addr, fl_addr;
    logic [DW-1:0] fl_wdata, fl_rdata;

    always #4 clk = ~clk;

    flash_burst_writer #(
        .AW(AW), .DW(DW), .CW(CW), .POLL_LIMIT(LIM),
        .UNLOCK_ADDR_A(UA), .UNLOCK_ADDR_B(UB)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .word_count(word_count), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .busy(busy), .done(done), .error(error),
        .err_addr(err_addr), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_we(fl_we), .fl_rd(fl_rd), .fl_rdata(fl_rdata)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // flash model state
    logic [DW-1:0] mem [MS];
    int unl = 0;
    bit byp = 0, armed = 0, exit_half = 0, dq5f = 0;
    int st = 0;          // 0 ready, 1 programming, 2 failed, 3 hung
    int busy_cnt = 0;
    int lat_cfg = 0;
    bit hang_en = 0;
    int hang_addr = 0;
    logic [DW-1:0] tgt = '0;
    logic [AW-1:0] tgt_a = '0;
    int writes = 0, viol = 0, entries = 0, exits = 0;

    function automatic logic [15:0] pat(int a);
        return 16'((a * 693 + 451) ^ (a << 9));
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (fl_rd && st != 0 && fl_addr != tgt_a) viol++;
        if (fl_we) begin
            writes++;
            if (!byp) begin
                if (unl == 0 && int'(fl_addr) == UA && fl_wdata == 16'hAA) unl = 1;
                else if (unl == 1 && int'(fl_addr) == UB && fl_wdata == 16'h55) unl = 2;
                else if (unl == 2 && int'(fl_addr) == UA && fl_wdata == 16'h20) begin
                    unl = 0; byp = 1; entries++;
                end else viol++;
            end else if (st == 1) begin
                viol++;
            end else if (exit_half) begin
                if (fl_wdata == 16'h00) begin byp = 0; exits++; exit_half = 0; st = 0; end
                else viol++;
            end else if (armed && st == 0) begin
                armed = 0;
                dq5f = (mem[fl_addr][7] & fl_wdata[7]) != fl_wdata[7];
                mem[fl_addr] = mem[fl_addr] & fl_wdata;
                tgt = fl_wdata; tgt_a = fl_addr;
                if (hang_en && int'(fl_addr) == hang_addr) st = 3;
                else begin st = 1; busy_cnt = lat_cfg; end
            end else if (fl_wdata == 16'hA0 && st == 0) armed = 1;
            else if (fl_wdata == 16'h90) exit_half = 1;
            else viol++;
        end else if (st == 1) begin
            if (busy_cnt == 0) st = dq5f ? 2 : 0;
            else busy_cnt--;
        end
    end

    always_comb begin
        if (st == 1 || st == 3) fl_rdata = {8'h00, ~tgt[7], 7'h00};
        else if (st == 2)       fl_rdata = {8'h00, ~tgt[7], 1'b0, 1'b1, 5'h00};
        else                    fl_rdata = mem[fl_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < MS; i++) mem[i] = 16'hFFFF;
        unl = 0; byp = 0; armed = 0; exit_half = 0; st = 0;
        writes = 0; viol = 0; entries = 0; exits = 0; hang_en = 0;
    endtask

    int taken_words;
    bit pulse_ok;

    task automatic run(input int sa, input int n, input bit poke);
        int cyc = 0;
        int gap = 0;
        bit taken = 0, fin = 0;
        taken_words = 0; pulse_ok = 0;
        @(negedge clk);
        start_addr = AW'(sa); word_count = CW'(n); start = 1;
        while (!fin) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 0;
            if (poke && cyc == 6) begin start = 1; start_addr = AW'(900); word_count = 3; end
            if (poke && cyc == 7) start = 0;
            if (done) begin
                fin = 1;
                wr_valid = 0;
                @(negedge clk);
                pulse_ok = !done && !busy;
            end else begin
                if (taken) begin taken = 0; wr_valid = 0; taken_words++; gap = taken_words % 3; end
                if (!wr_valid && taken_words < n) begin
                    if (gap > 0) gap--;
                    else begin wr_valid = 1; wr_data = pat(sa + taken_words); end
                end
                if (wr_valid && wr_ready) taken = 1;
                if (cyc > 3000) begin
                    chk(0, "R10 run hung", cyc, 0);
                    fin = 1;
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int starts[3];
        int counts[3];
        int bad, b, fa;
        logic [15:0] pre;
        starts = '{0, 37, 250};
        counts = '{1, 2, 5};
        model_clear();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !fl_we && !fl_rd && !wr_ready && !error,
            "R10 reset state", {busy, done, fl_we, fl_rd, wr_ready}, 0);

        // R1: zero-length request
        model_clear();
        run(100, 0, 0);
        chk(writes == 0, "R1 no bus writes", writes, 0);
        chk(!error, "R1 no error", error, 0);
        chk(pulse_ok, "R10 done pulse (zero count)", pulse_ok, 1);

        // Sweep start address x count x latency (R2 R3 R4 R8 R9 R10)
        for (int si = 0; si < 3; si++)
            for (int ci = 0; ci < 3; ci++)
                for (int lat = 0; lat < 4; lat += 3) begin
                    model_clear();
                    lat_cfg = lat;
                    run(starts[si], counts[ci], (si == 1 && ci == 2));
                    bad = 0;
                    for (int a = 0; a < MS; a++)
                        if (mem[a] != ((a >= starts[si] && a < starts[si] + counts[ci]) ? pat(a) : 16'hFFFF)) bad++;
                    chk(bad == 0, "R9 memory image", bad, 0);
                    chk(!error, "R5 no error on clean run", error, 0);
                    chk(viol == 0, "R2 R4 protocol order", viol, 0);
                    chk(writes == 5 + 2 * counts[ci], "R3 write count", writes, 5 + 2 * counts[ci]);
                    chk(taken_words == counts[ci], "R3 words fetched", taken_words, counts[ci]);
                    chk(entries == 1 && exits == 1 && !byp, "R8 bypass exit", exits, 1);
                    chk(pulse_ok, "R10 done pulse", pulse_ok, 1);
                end

        // R5: read-back mismatch (0 to 1 attempt on a bit other than bit 7)
        model_clear();
        lat_cfg = 1;
        b = 0;
        for (int k = 15; k >= 0; k--) if (k != 7 && pat(12)[k]) b = k;
        mem[12] = 16'hFFFF & ~(16'(1) << b);
        run(10, 4, 0);
        chk(error == 1, "R5 error flag", error, 1);
        chk(err_addr == 12, "R5 err_addr", err_addr, 12);
        chk(mem[13] == 16'hFFFF && mem[11] == pat(11), "R5 run stopped", mem[13], 16'hFFFF);
        chk(taken_words == 3 && writes == 5 + 6, "R5 words used", taken_words, 3);
        chk(exits == 1 && viol == 0, "R8 exit after mismatch", exits, 1);

        // R6: status bit 5 failure
        model_clear();
        lat_cfg = 2;
        fa = 41;
        while (!pat(fa)[7]) fa++;
        pre = 16'hFF7F;
        mem[fa] = pre;
        run(40, fa - 40 + 2, 0);
        chk(error == 1, "R6 error flag", error, 1);
        chk(err_addr == AW'(fa), "R6 err_addr", err_addr, fa);
        chk(mem[fa + 1] == 16'hFFFF, "R6 run stopped", mem[fa + 1], 16'hFFFF);
        chk(exits == 1 && viol == 0, "R8 exit after status fail", exits, 1);

        // R7: poll timeout
        model_clear();
        lat_cfg = 0;
        hang_en = 1; hang_addr = 70;
        run(68, 4, 0);
        chk(error == 1, "R7 error flag", error, 1);
        chk(err_addr == 70, "R7 err_addr", err_addr, 70);
        chk(mem[71] == 16'hFFFF && mem[69] == pat(69), "R7 run stopped", mem[71], 16'hFFFF);
        chk(exits == 1 && viol == 0, "R8 exit after timeout", exits, 1);

        // Error clears on next run
        model_clear();
        run(200, 2, 0);
        chk(!error && mem[201] == pat(201), "R5 error cleared by new run", error, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule